// File: doc/BRIEF.md
# MIDI Host Port Controller with Command Emulation

This block sits between a host bus and a MIDI serial link. It presents two byte-wide addresses: address 0 carries data and address 1 carries commands on writes and status on reads. The block has two modes. In command mode it answers each command byte by putting an acknowledge byte, and sometimes one reply byte, into a receive FIFO. In pass-through mode it moves host bytes out through a serial transmitter and passes serially received bytes back to the host.

Both directions use 16-entry FIFOs. The serial line runs at 31.25 kbaud with one start bit, eight data bits sent least significant bit first, and one stop bit. One bit lasts `TICK_DIV*OVERSAMPLE` clocks, so a 16 MHz clock with `TICK_DIV=32` gives the nominal rate. The interrupt output stays high for as long as the receive FIFO holds a byte.

The host must leave at least two clock cycles between two command writes, because a reply byte enters the FIFO one cycle after its acknowledge.

Top module: `midi_port_ctrl`

## Requirements
- R1: After reset the block is in command mode, `irq` is 0, `midi_txd` is 1, status reads BFh and a data read returns 00h.
- R2: In command mode, writes to address 0 are discarded: the transmit line stays idle high and status bit 6 stays 0.
- R3: In command mode, command 3Fh selects pass-through mode and places FEh into the receive FIFO.
- R4: In command mode, commands A0h to A7h and ABh place FEh and then 00h in the FIFO. ACh places FEh then 15h, ADh places FEh then 01h, and AFh places FEh then 64h.
- R5: In command mode, any other command byte places FEh alone.
- R6: In command mode, a read of address 0 returns the oldest FIFO byte without removing it. When the FIFO is empty, it returns the byte most recently removed, or 00h if none has been removed since reset.
- R7: In pass-through mode, a byte written to address 0 is sent on `midi_txd` as a 0 start bit, 8 data bits LSB first and a 1 stop bit, each lasting `TICK_DIV*OVERSAMPLE` clocks. Queued bytes follow one another.
- R8: In pass-through mode, a read of address 0 removes and returns the oldest byte. Each serially received byte is appended to the FIFO. When the FIFO is full, a new byte replaces the newest stored entry.
- R9: In pass-through mode, command FFh returns the block to command mode, and every other command byte is ignored. Neither case places any byte in the FIFO.
- R10: Status is {bit 7 = receive FIFO empty, bit 6 = transmit FIFO full, bits 5:0 = 1}.
- R11: `irq` is 1 exactly while the receive FIFO is non-empty.
- R12: The receiver discards a start pulse that is no longer low at mid-bit, and it discards a frame whose stop bit samples 0.
- R13: In command mode, serially received bytes are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_addr | input | 1 | 0 = data, 1 = command/status |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for the current address |
| irq | output | 1 | High while receive FIFO holds data |
| midi_txd | output | 1 | Serial output, idle high |
| midi_rxd | input | 1 | Serial input, idle high |

## Verification
The hardest case to reach is a full receive FIFO taking yet another byte, because each serial byte costs a whole frame time. The bench enters pass-through mode with the acknowledge byte still queued and streams seventeen frames without reading. It then drains the FIFO and expects the last stored entry to be the seventeenth byte. Constrained-random phases then mix commands, reads and serial frames in both modes, so acknowledge bytes pile up and also overflow.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;
    typedef enum logic {MODE_CMD = 1'b0, MODE_PASS = 1'b1} mode_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;

    localparam logic [7:0] ACK_BYTE  = 8'hFE;
    localparam logic [7:0] CMD_ENTER = 8'h3F;
    localparam logic [7:0] CMD_LEAVE = 8'hFF;

    // {reply present, reply byte} for a command seen in command mode
    function automatic logic [8:0] reply_for(input logic [7:0] cmd);
        if (cmd[7:3] == 5'b10100 || cmd == 8'hAB) return {1'b1, 8'h00};
        case (cmd)
            8'hAC:   return {1'b1, 8'h15};
            8'hAD:   return {1'b1, 8'h01};
            8'hAF:   return {1'b1, 8'h64};
            default: return 9'h000;
        endcase
    endfunction
endpackage

// File: rtl/midi_byte_fifo.sv
module midi_byte_fifo #(
    parameter int WIDTH     = 8,
    parameter int DEPTH     = 16,
    parameter bit OVERWRITE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_s;

    fifo_s q, d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             we_d;
    logic [AW-1:0]    waddr_d;
    logic             take_pop, take_push;

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
    assign dout  = mem_q[q.rp];

    always_comb begin
        d         = q;
        we_d      = 1'b0;
        waddr_d   = q.wp;
        take_pop  = pop && !empty;
        take_push = 1'b0;
        if (push) begin
            if (!full || take_pop) begin
                we_d      = 1'b1;
                take_push = 1'b1;
                d.wp      = q.wp + 1'b1;
            end else if (OVERWRITE) begin
                we_d    = 1'b1;
                waddr_d = q.wp - 1'b1;
            end
        end
        if (take_pop) d.rp = q.rp + 1'b1;
        d.cnt = q.cnt + CW'(take_push) - CW'(take_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
        if (we_d) mem_q[waddr_d] <= din;
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH)); // R8
    AST_FIFO_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full); // R8
endmodule

// File: rtl/midi_ser_tx.sv
module midi_ser_tx #(
    parameter int BIT_CLKS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       have_data,
    input  logic [7:0] data,
    output logic       take,
    output logic       txd
);
    localparam int CW = $clog2(BIT_CLKS);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [3:0]    idx;
        logic [9:0]    sh;
    } tx_s;

    tx_s q, d;

    assign txd = q.busy ? q.sh[0] : 1'b1;

    always_comb begin
        d    = q;
        take = 1'b0;
        if (!q.busy) begin
            if (have_data) begin
                take   = 1'b1;
                d.busy = 1'b1;
                d.sh   = {1'b1, data, 1'b0};
                d.cnt  = '0;
                d.idx  = '0;
            end
        end else if (q.cnt == CW'(BIT_CLKS - 1)) begin
            d.cnt = '0;
            d.sh  = {1'b1, q.sh[9:1]};
            d.idx = q.idx + 1'b1;
            if (q.idx == 4'd9) d.busy = 1'b0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{busy: 1'b0, cnt: '0, idx: '0, sh: '1};
        else        q <= d;
    end

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> !txd); // R7
    AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> $past(txd)); // R7
endmodule

// File: rtl/midi_ser_rx.sv
module midi_ser_rx #(
    parameter int BIT_CLKS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    output logic       valid,
    output logic [7:0] data
);
    import midi_port_pkg::*;
    localparam int CW   = $clog2(BIT_CLKS);
    localparam int HALF = BIT_CLKS / 2;

    typedef struct packed {
        rx_st_e                 st;
        logic [CW-1:0]          cnt;
        logic [2:0]             idx;
        logic [7:0]             sh;
        logic [SYNC_STAGES-1:0] sync;
        logic                   vld;
    } rx_s;

    rx_s  q, d;
    logic line;

    assign line  = q.sync[SYNC_STAGES-1];
    assign valid = q.vld;
    assign data  = q.sh;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], rxd};
        d.vld  = 1'b0;
        d.cnt  = q.cnt + 1'b1;
        case (q.st)
            RX_IDLE: if (!line) begin
                d.st  = RX_START;
                d.cnt = '0;
            end
            RX_START: if (q.cnt == CW'(HALF - 1)) begin
                d.st  = line ? RX_IDLE : RX_DATA;
                d.cnt = '0;
                d.idx = '0;
            end
            RX_DATA: if (q.cnt == CW'(BIT_CLKS - 1)) begin
                d.cnt = '0;
                d.sh  = {line, q.sh[7:1]};
                d.idx = q.idx + 1'b1;
                if (q.idx == 3'd7) d.st = RX_STOP;
            end
            default: if (q.cnt == CW'(BIT_CLKS - 1)) begin
                d.vld = line;
                d.st  = RX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: RX_IDLE, cnt: '0, idx: '0, sh: '0, sync: '1, vld: 1'b0};
        else        q <= d;
    end

    AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R12
    AST_RX_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(q.st == RX_STOP)); // R12
endmodule

// File: rtl/midi_port_ctrl.sv
module midi_port_ctrl #(
    parameter int DEPTH       = 16,
    parameter int TICK_DIV    = 2,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       irq,
    output logic       midi_txd,
    input  logic       midi_rxd
);
    import midi_port_pkg::*;
    localparam int BIT_CLKS = TICK_DIV * OVERSAMPLE;

    typedef struct packed {
        mode_e      mode;
        logic       pend_v;
        logic [7:0] pend_b;
        logic [7:0] last_b;
    } ctl_s;

    ctl_s q, d;
    logic       rx_push, rx_pop, rx_empty, rx_full;
    logic [7:0] rx_din, rx_head;
    logic       tx_push, tx_take, tx_empty, tx_full;
    logic [7:0] tx_head;
    logic       ser_vld;
    logic [7:0] ser_byte;
    logic       cmd_wr, dat_wr, dat_rd;
    logic [8:0] rpl;

    assign cmd_wr = host_wr &&  host_addr;
    assign dat_wr = host_wr && !host_addr;
    assign dat_rd = host_rd && !host_addr;
    assign rpl    = reply_for(host_wdata);

    always_comb begin
        d       = q;
        rx_push = 1'b0;
        rx_din  = ser_byte;
        rx_pop  = 1'b0;
        tx_push = 1'b0;
        if (q.pend_v) begin
            rx_push  = 1'b1;
            rx_din   = q.pend_b;
            d.pend_v = 1'b0;
        end else if (q.mode == MODE_PASS && ser_vld) begin
            rx_push = 1'b1;
        end
        if (q.mode == MODE_CMD) begin
            if (cmd_wr) begin
                rx_push  = 1'b1;
                rx_din   = ACK_BYTE;
                d.pend_v = rpl[8];
                d.pend_b = rpl[7:0];
                if (host_wdata == CMD_ENTER) d.mode = MODE_PASS;
            end
        end else begin
            if (cmd_wr && host_wdata == CMD_LEAVE) d.mode = MODE_CMD;
            tx_push = dat_wr;
            if (dat_rd && !rx_empty) begin
                rx_pop   = 1'b1;
                d.last_b = rx_head;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{mode: MODE_CMD, pend_v: 1'b0, pend_b: '0, last_b: '0};
        else        q <= d;
    end

    assign host_rdata = host_addr ? {rx_empty, tx_full, 6'h3F}
                                  : (rx_empty ? q.last_b : rx_head);
    assign irq = !rx_empty;

    midi_byte_fifo #(.WIDTH(8), .DEPTH(DEPTH), .OVERWRITE(1'b1)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din), .pop(rx_pop),
        .dout(rx_head), .empty(rx_empty), .full(rx_full));

    midi_byte_fifo #(.WIDTH(8), .DEPTH(DEPTH), .OVERWRITE(1'b0)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(host_wdata), .pop(tx_take),
        .dout(tx_head), .empty(tx_empty), .full(tx_full));

    midi_ser_tx #(.BIT_CLKS(BIT_CLKS)) tx_i (
        .clk(clk), .rst_n(rst_n), .have_data(!tx_empty), .data(tx_head),
        .take(tx_take), .txd(midi_txd));

    midi_ser_rx #(.BIT_CLKS(BIT_CLKS), .SYNC_STAGES(SYNC_STAGES)) rx_i (
        .clk(clk), .rst_n(rst_n), .rxd(midi_rxd), .valid(ser_vld), .data(ser_byte));

    AST_ENTER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_CMD && cmd_wr && host_wdata == CMD_ENTER)
        |=> (q.mode == MODE_PASS && irq)); // R3
    AST_REPLY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_CMD && cmd_wr && rpl[8]) |=> rx_push); // R4
    AST_PASS_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_PASS && !q.pend_v && !ser_vld) |-> !rx_push); // R9
    AST_CMD_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_CMD && dat_wr) |=> $stable(tx_full)); // R2
endmodule

// File: tb/midi_port_ctrl_tb.sv
module midi_port_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int BIT_CLKS   = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0, host_addr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq, midi_txd;
    logic       midi_rxd = 1'b1;

    int nvec = 0, nfail = 0;
    logic [7:0] mq[$];
    logic [7:0] last_b = 8'h00;
    bit         pass_mode = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    midi_port_ctrl #(.DEPTH(DEPTH), .TICK_DIV(2), .OVERSAMPLE(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .midi_txd(midi_txd), .midi_rxd(midi_rxd));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [8:0] exp_reply(input logic [7:0] c);
        if (c >= 8'hA0 && c <= 8'hA7) return {1'b1, 8'h00};
        if (c == 8'hAB) return {1'b1, 8'h00};
        if (c == 8'hAC) return {1'b1, 8'h15};
        if (c == 8'hAD) return {1'b1, 8'h01};
        if (c == 8'hAF) return {1'b1, 8'h64};
        return 9'h0;
    endfunction

    function automatic logic [7:0] exp_status(input bit txfull);
        return {mq.size() == 0, txfull, 6'h3F};
    endfunction

    function automatic logic [7:0] exp_data();
        return (mq.size() == 0) ? last_b : mq[0];
    endfunction

    task automatic model_push(input logic [7:0] b);
        if (mq.size() == DEPTH) mq[DEPTH-1] = b;
        else mq.push_back(b);
    endtask

    task automatic hwrite(input logic a, input logic [7:0] v);
        @(negedge clk);
        host_addr = a; host_wdata = v; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic a, output logic [7:0] v);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic do_cmd(input logic [7:0] c);
        logic [8:0] r;
        hwrite(1'b1, c);
        repeat (2) @(negedge clk);
        if (!pass_mode) begin
            r = exp_reply(c);
            model_push(8'hFE);
            if (r[8]) model_push(r[7:0]);
            if (c == 8'h3F) pass_mode = 1'b1;
        end else if (c == 8'hFF) pass_mode = 1'b0;
    endtask

    task automatic send_serial(input logic [7:0] b, input logic stopv);
        @(negedge clk);
        midi_rxd = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            midi_rxd = b[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        midi_rxd = stopv;
        repeat (BIT_CLKS) @(negedge clk);
        midi_rxd = 1'b1;
        repeat (stopv ? 4 : BIT_CLKS + 4) @(negedge clk);
    endtask

    task automatic get_tx(output logic [7:0] b, output logic ok);
        int t = 0;
        ok = 1'b1;
        b = '0;
        while (midi_txd && t < 4000) begin
            @(negedge clk);
            t++;
        end
        repeat (BIT_CLKS / 2 - 1) @(negedge clk);
        if (midi_txd !== 1'b0) ok = 1'b0;
        for (int i = 0; i < 8; i++) begin
            repeat (BIT_CLKS) @(negedge clk);
            b[i] = midi_txd;
        end
        repeat (BIT_CLKS) @(negedge clk);
        if (midi_txd !== 1'b1) ok = 1'b0;
    endtask

    task automatic chk_status(input string req, input bit txfull);
        logic [7:0] v;
        hread(1'b1, v);
        check(req, v, exp_status(txfull));
        check({req, " irq"}, {7'd0, irq}, {7'd0, mq.size() != 0});
    endtask

    task automatic chk_data(input string req);
        logic [7:0] v;
        logic [7:0] e;
        e = exp_data();
        hread(1'b0, v);
        check(req, v, e);
        if (pass_mode && mq.size() != 0) last_b = mq.pop_front();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [7:0] v, b1, b2;
        logic ok1, ok2;
        int seed_tmp;
        bit hi;
        seed_tmp = $urandom(32'h1F2E3D4C);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        hread(1'b1, v); check("R1 status", v, 8'hBF);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 txd", {7'd0, midi_txd}, 8'h01);
        hread(1'b0, v); check("R1 data", v, 8'h00);

        // R2 data write ignored in command mode
        hwrite(1'b0, 8'h55);
        hi = 1'b1;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (!midi_txd) hi = 1'b0;
        end
        check("R2 txd idle", {7'd0, hi}, 8'h01);
        chk_status("R2 status", 1'b0);

        // R4 / R5 command replies, R6 non-removing read
        do_cmd(8'hA3); chk_data("R4 A3 ack"); chk_data("R6 no pop");
        do_cmd(8'hAC); do_cmd(8'hAD); do_cmd(8'hAF); do_cmd(8'hAB);
        do_cmd(8'h12);
        chk_status("R11 status nonempty", 1'b0);
        // R13 serial byte discarded in command mode
        send_serial(8'h77, 1'b1);
        chk_status("R13 status", 1'b0);

        // R3 enter pass-through, then drain and check the queued sequence
        do_cmd(8'h3F);
        while (mq.size() != 0) chk_data("R8/R4/R5 drain");
        chk_data("R6 empty returns last");
        chk_status("R3 status empty", 1'b0);

        // R9 other commands ignored in pass-through mode
        do_cmd(8'h3F); do_cmd(8'hA0);
        chk_status("R9 no ack", 1'b0);

        // R7 transmit two back-to-back bytes
        fork
            begin get_tx(b1, ok1); get_tx(b2, ok2); end
            begin hwrite(1'b0, 8'hA5); hwrite(1'b0, 8'h3C); end
        join
        check("R7 byte1", b1, 8'hA5); check("R7 frame1", {7'd0, ok1}, 8'h01);
        check("R7 byte2", b2, 8'h3C); check("R7 frame2", {7'd0, ok2}, 8'h01);

        // R12 glitch and framing error rejected
        @(negedge clk); midi_rxd = 1'b0; repeat (3) @(negedge clk); midi_rxd = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        chk_status("R12 glitch", 1'b0);
        send_serial(8'h5A, 1'b0);
        chk_status("R12 framing", 1'b0);

        // R8 overflow: 17 frames into a FIFO with room for 16
        do_cmd(8'hFF); do_cmd(8'h3F);
        for (int i = 1; i <= 17; i++) begin
            send_serial(8'(i * 7), 1'b1);
            model_push(8'(i * 7));
        end
        chk_status("R8 full status", 1'b0);
        while (mq.size() != 0) chk_data("R8 overwrite drain");

        // constrained random phase
        for (int it = 0; it < 300; it++) begin
            int r;
            logic [7:0] c;
            r = $urandom_range(0, 9);
            if (!pass_mode) begin
                if (r <= 4) begin
                    case ($urandom_range(0, 2))
                        0: c = 8'(8'hA0 + $urandom_range(0, 7));
                        1: c = (r[0]) ? 8'hAB : 8'(8'hAC + $urandom_range(0, 1));
                        default: c = 8'($urandom_range(0, 255));
                    endcase
                    if (c == 8'h3F) c = 8'hAF;
                    do_cmd(c);
                end else if (r <= 6) chk_data("R6 random read");
                else if (r == 7) hwrite(1'b0, 8'($urandom_range(0, 255)));
                else if (r == 8) send_serial(8'($urandom_range(0, 255)), 1'b1);
                else do_cmd(8'h3F);
                chk_status("R10 random cmd-mode", 1'b0);
            end else begin
                if (r <= 2) begin
                    c = 8'($urandom_range(0, 255));
                    send_serial(c, 1'b1);
                    model_push(c);
                end else if (r <= 5) chk_data("R8 random read");
                else if (r == 6) do_cmd(8'($urandom_range(0, 254)));
                else if (r == 7) do_cmd(8'hFF);
                chk_status("R9 random pass-mode", 1'b0);
            end
        end

        // R10 transmit FIFO full
        if (!pass_mode) do_cmd(8'h3F);
        for (int i = 0; i < 17; i++) hwrite(1'b0, 8'(i));
        hread(1'b1, v);
        check("R10 tx full bit", v[6] ? 8'h01 : 8'h00, 8'h01);
        repeat (17 * 10 * BIT_CLKS + 200) @(negedge clk);
        hread(1'b1, v);
        check("R10 tx drained bit", v[6] ? 8'h01 : 8'h00, 8'h00);
        check("R7 idle after drain", {7'd0, midi_txd}, 8'h01);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule